// File: doc/BRIEF.md
# Retire-Gated Store Commit Queue

This block sits between a core's execution pipeline and its first-level data cache and holds byte stores that have executed but are not yet visible to other agents. Each stored entry carries an address, one data byte and a tag. Entries stay private and speculative until the core declares them retired. Retirement is given as a count: the oldest still-speculative entries are marked, in program order. From then on the block guarantees that the store will reach the cache, and the pipeline does not have to wait for it.

The oldest retired entry is committed only after the coherence side grants exclusive ownership of its cache line. The block raises a request carrying the line address and keeps it up, unchanged, for as long as the grant is withheld. After a grant it issues exactly one write to the cache and removes the entry. Commits leave strictly in program order, so no younger entry can overtake a head that is waiting. A flush input discards every speculative entry in a single cycle, for branch misprediction or fault recovery, and keeps every retired entry.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty: enq_ready is 1, own_req is 0 and wr_valid is 0.
- R2: A store is taken when enq_valid and enq_ready are both 1 at a clock edge. enq_ready is 0 while DEPTH entries are held, and a store offered then is not taken.
- R3: No entry requests ownership or writes before it is retired. retire_cnt marks that many of the oldest unretired entries present at the start of the cycle. Any part of the count beyond the number of unretired entries is ignored, so stores enqueued later stay unretired.
- R4: While the oldest entry is retired and no write is in progress, own_req is 1 and own_line equals the entry address shifted right by OFS_W bits. While own_grant is 0, own_req stays 1 with own_line unchanged, and no write is issued.
- R5: own_grant equal to 1 in a cycle with own_req equal to 1 causes wr_valid to be 1 for exactly the following cycle. In that cycle wr_addr, wr_data and wr_tag carry the oldest entry, and the entry is then removed.
- R6: Writes leave in the order the stores were enqueued.
- R7: When flush is 1, every entry that is unretired after that cycle's retire_cnt has been applied is dropped. A store offered in the same cycle is also dropped. Retired entries are kept and still commit.
- R8: With own_grant held at 1 and retired entries waiting, consecutive writes are two cycles apart: one request cycle, then one write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Executed store offered |
| enq_ready | output | 1 | Queue can take a store |
| enq_addr | input | ADDR_W | Byte address of the store |
| enq_data | input | DATA_W | Store data byte |
| enq_tag | input | TAG_W | Instruction tag |
| retire_cnt | input | CNT_W | Number of oldest unretired entries to retire this cycle |
| flush | input | 1 | Drop all unretired entries |
| own_req | output | 1 | Request exclusive ownership of own_line |
| own_line | output | ADDR_W-OFS_W | Line address of the head entry |
| own_grant | input | 1 | Ownership granted (0 = not yet) |
| wr_valid | output | 1 | Cache write strobe |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |
| wr_tag | output | TAG_W | Tag of the committed store |

## Verification
A wrong retired count or retired flag shows up at the ports as a request for a store that is still speculative, or as a retired store that never requests ownership. Either becomes visible within two cycles of the retire. A corrupted head or tail pointer shows up as a write with the wrong address, data or tag, or as stores out of order, at the next commit. A wrong flush count shows up later, as writes of dropped stores or as missing writes of kept ones. The sweep therefore covers every retire count combined with and without a flush, and compares the whole commit stream against the expected sequence.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
    typedef enum logic {
        CM_WAIT  = 1'b0,
        CM_WRITE = 1'b1
    } commit_st_e;
endpackage

// File: rtl/sq_store_ram.sv
`timescale 1ns/1ps
module sq_store_ram #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int TAG_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [TAG_W-1:0]         wtag,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [ADDR_W-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata,
    output logic [TAG_W-1:0]         rtag
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
    } ram_t;

    ram_t ram_d, ram_q;

    always_comb begin
        ram_d = ram_q;
        if (we) begin
            ram_d.addr[widx] = waddr;
            ram_d.data[widx] = wdata;
            ram_d.tag[widx]  = wtag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ram_q <= '0;
        else        ram_q <= ram_d;
    end

    assign raddr = ram_q.addr[ridx];
    assign rdata = ram_q.data[ridx];
    assign rtag  = ram_q.tag[ridx];
endmodule

// File: rtl/sq_ctrl.sv
`timescale 1ns/1ps
module sq_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             flush,
    input  logic [CNT_W-1:0] retire_cnt,
    input  logic             pop,
    output logic             enq_ready,
    output logic             push,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             head_ret,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] nret
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] nret;
        logic [DEPTH-1:0] flags;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [CNT_W-1:0] unret;
    logic [CNT_W-1:0] rcnt;

    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    assign enq_ready = (c_q.count != CNT_W'(DEPTH));

    always_comb begin
        c_d   = c_q;
        unret = c_q.count - c_q.nret;
        rcnt  = (retire_cnt > unret) ? unret : retire_cnt;
        push  = enq_valid && enq_ready && !flush;

        // mark the next rcnt speculative entries as retired, oldest first
        for (int j = 0; j < DEPTH; j++) begin
            int off;
            off = (j + DEPTH - int'(c_q.head)) % DEPTH;
            if (off >= int'(c_q.nret) && off < int'(c_q.nret) + int'(rcnt))
                c_d.flags[j] = 1'b1;
        end

        if (pop) begin
            c_d.flags[c_q.head] = 1'b0;
            c_d.head            = ptr_add(c_q.head, CNT_W'(1));
        end

        c_d.nret = c_q.nret + rcnt - CNT_W'(pop);

        if (flush) begin
            c_d.count = c_d.nret;
            c_d.tail  = ptr_add(c_d.head, c_d.nret);
        end else begin
            c_d.count = c_q.count + CNT_W'(push) - CNT_W'(pop);
            if (push) begin
                c_d.flags[c_q.tail] = 1'b0;
                c_d.tail            = ptr_add(c_q.tail, CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign head     = c_q.head;
    assign tail     = c_q.tail;
    assign head_ret = c_q.flags[c_q.head];
    assign count    = c_q.count;
    assign nret     = c_q.nret;
endmodule

// File: rtl/sq_commit.sv
`timescale 1ns/1ps
module sq_commit
    import sq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    head_ret,
    input  logic [ADDR_W-1:0]       head_addr,
    input  logic                    own_grant,
    output logic                    own_req,
    output logic [ADDR_W-OFS_W-1:0] own_line,
    output logic                    wr_valid,
    output logic                    pop
);
    typedef struct packed {
        commit_st_e st;
    } cm_t;

    cm_t m_d, m_q;

    assign own_req  = (m_q.st == CM_WAIT) && head_ret;
    assign own_line = head_addr[ADDR_W-1:OFS_W];
    assign wr_valid = (m_q.st == CM_WRITE);
    assign pop      = wr_valid;

    always_comb begin
        m_d = m_q;
        unique case (m_q.st)
            CM_WAIT:  if (own_req && own_grant) m_d.st = CM_WRITE;
            CM_WRITE: m_d.st = CM_WAIT;
            default:  m_d.st = CM_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{st: CM_WAIT};
        else        m_q <= m_d;
    end
endmodule

// File: rtl/store_commit_queue.sv
`timescale 1ns/1ps
module store_commit_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int TAG_W  = 4,
    parameter int OFS_W  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LINE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic [CNT_W-1:0]  retire_cnt,
    input  logic              flush,
    output logic              own_req,
    output logic [LINE_W-1:0] own_line,
    input  logic              own_grant,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [TAG_W-1:0]  wr_tag
);
    logic             push_w;
    logic             pop_w;
    logic             head_ret_w;
    logic [PTR_W-1:0] head_w;
    logic [PTR_W-1:0] tail_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] nret_w;

    sq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (enq_valid),
        .flush      (flush),
        .retire_cnt (retire_cnt),
        .pop        (pop_w),
        .enq_ready  (enq_ready),
        .push       (push_w),
        .head       (head_w),
        .tail       (tail_w),
        .head_ret   (head_ret_w),
        .count      (count_w),
        .nret       (nret_w)
    );

    sq_store_ram #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_w),
        .widx  (tail_w),
        .waddr (enq_addr),
        .wdata (enq_data),
        .wtag  (enq_tag),
        .ridx  (head_w),
        .raddr (wr_addr),
        .rdata (wr_data),
        .rtag  (wr_tag)
    );

    sq_commit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_ret  (head_ret_w),
        .head_addr (wr_addr),
        .own_grant (own_grant),
        .own_req   (own_req),
        .own_line  (own_line),
        .wr_valid  (wr_valid),
        .pop       (pop_w)
    );
endmodule

// File: rtl/sq_checker.sv
`timescale 1ns/1ps
module sq_checker #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 12,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              own_req,
    input logic              own_grant,
    input logic [LINE_W-1:0] own_line,
    input logic              wr_valid,
    input logic              flush,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  nret
);
    // R5: a write only follows a granted request
    p_write_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(own_req && own_grant));

    // R8: one write per grant, never back to back
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R4: a refused request is held with the same line
    p_req_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && !own_grant) |=> (own_req && $stable(own_line)));

    // R3: retired entries never outnumber held entries
    p_retired_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nret <= count);

    // R3: a request implies at least one retired entry
    p_req_needs_retired_r3: assert property (@(posedge clk) disable iff (!rst_n)
        own_req |-> (nret != '0));

    // R7: a flush never grows the queue
    p_flush_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count <= $past(count)));
endmodule

bind store_commit_queue sq_checker #(.DEPTH(DEPTH), .LINE_W(LINE_W)) i_sq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_req   (own_req),
    .own_grant (own_grant),
    .own_line  (own_line),
    .wr_valid  (wr_valid),
    .flush     (flush),
    .count     (count_w),
    .nret      (nret_w)
);

// File: tb/test_store_commit_queue.sv
`timescale 1ns/1ps
module test_store_commit_queue;
    localparam int DEPTH = 4, ADDR_W = 16, DATA_W = 8, TAG_W = 4, OFS_W = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic enq_ready;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic [DATA_W-1:0] enq_data = '0;
    logic [TAG_W-1:0]  enq_tag = '0;
    logic [CNT_W-1:0]  retire_cnt = '0;
    logic flush = 1'b0;
    logic own_req;
    logic [ADDR_W-OFS_W-1:0] own_line;
    logic own_grant = 1'b0;
    logic wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [TAG_W-1:0]  wr_tag;

    store_commit_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                         .TAG_W(TAG_W), .OFS_W(OFS_W)) i_store_commit_queue (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_addr(enq_addr), .enq_data(enq_data), .enq_tag(enq_tag),
        .retire_cnt(retire_cnt), .flush(flush), .own_req(own_req),
        .own_line(own_line), .own_grant(own_grant), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_tag(wr_tag));

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0, ncap = 0;
    int gmode = 0;
    logic [ADDR_W-1:0] cap_addr [32];
    logic [DATA_W-1:0] cap_data [32];
    logic [TAG_W-1:0]  cap_tag  [32];
    int                cap_cyc  [32];

    function automatic logic [ADDR_W-1:0] x_addr(int s, int i);
        return ADDR_W'(s * 64 + i * 20 + 3);
    endfunction
    function automatic logic [DATA_W-1:0] x_data(int s, int i);
        return DATA_W'(s * 7 + i * 13 + 1);
    endfunction
    function automatic logic [TAG_W-1:0] x_tag(int s, int i);
        return TAG_W'(i + s);
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst_n && wr_valid && ncap < 32) begin
            cap_addr[ncap] = wr_addr;
            cap_data[ncap] = wr_data;
            cap_tag[ncap]  = wr_tag;
            cap_cyc[ncap]  = cyc;
            ncap++;
        end
        own_grant = (gmode == 1) ? 1'b1 : (gmode == 2) ? (cyc % 3 == 0) : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_store(input int s, input int i);
        enq_valid = 1'b1;
        enq_addr = x_addr(s, i); enq_data = x_data(s, i); enq_tag = x_tag(s, i);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic retire(input int n);
        retire_cnt = CNT_W'(n);
        @(negedge clk);
        retire_cnt = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_seq(input int s, input int n, input bit spacing);
        chk(ncap == n, "R6", "write count", ncap, n);
        for (int i = 0; i < n && i < ncap; i++) begin
            chk(cap_addr[i] == x_addr(s, i), "R6", "write addr", int'(cap_addr[i]), int'(x_addr(s, i)));
            chk(cap_data[i] == x_data(s, i), "R5", "write data", int'(cap_data[i]), int'(x_data(s, i)));
            chk(cap_tag[i] == x_tag(s, i), "R5", "write tag", int'(cap_tag[i]), int'(x_tag(s, i)));
            if (spacing && i > 0)
                chk(cap_cyc[i] - cap_cyc[i-1] == 2, "R8", "write spacing", cap_cyc[i] - cap_cyc[i-1], 2);
        end
    endtask

    initial begin
        #1000000;
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(enq_ready == 1'b1, "R1", "enq_ready", int'(enq_ready), 1);
        chk(own_req == 1'b0, "R1", "own_req", int'(own_req), 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid", int'(wr_valid), 0);

        // fill, then offer a fifth store while full
        ncap = 0;
        for (int i = 0; i < 4; i++) push_store(20, i);
        chk(enq_ready == 1'b0, "R2", "enq_ready when full", int'(enq_ready), 0);
        push_store(20, 9);
        idle(4);
        chk(own_req == 1'b0, "R3", "own_req before retire", int'(own_req), 0);
        chk(ncap == 0, "R3", "writes before retire", ncap, 0);

        // retire one with grant withheld
        retire(1);
        chk(own_req == 1'b1, "R4", "own_req after retire", int'(own_req), 1);
        chk(own_line == x_addr(20, 0) >> OFS_W, "R4", "own_line", int'(own_line), int'(x_addr(20, 0) >> OFS_W));
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            chk(own_req == 1'b1 && own_line == x_addr(20, 0) >> OFS_W, "R4", "held request", int'(own_req), 1);
        end
        chk(ncap == 0, "R4", "writes while denied", ncap, 0);

        gmode = 1;
        idle(3);
        chk(ncap == 1, "R5", "writes after grant", ncap, 1);
        idle(4);
        chk(ncap == 1, "R3", "unretired stay", ncap, 1);

        // over-count retire clamps, later store stays speculative
        retire(4);
        push_store(20, 3 + 1);
        idle(15);
        chk_seq(20, 4, 1'b0);
        chk(own_req == 1'b0, "R3", "late store unretired", int'(own_req), 0);

        // flush with a simultaneous enqueue: both speculative stores vanish
        flush = 1'b1;
        push_store(20, 5);
        flush = 1'b0;
        retire(4);
        idle(10);
        chk(ncap == 4, "R7", "writes after flush", ncap, 4);
        chk(enq_ready == 1'b1, "R7", "queue empty after flush", int'(enq_ready), 1);

        // sweep: grant mode x retire count x flush
        for (int g = 1; g <= 2; g++) begin
            for (int k = 0; k <= 4; k++) begin
                for (int f = 0; f <= 1; f++) begin
                    int s;
                    s = g * 10 + k * 2 + f;
                    gmode = g;
                    ncap = 0;
                    for (int i = 0; i < 4; i++) push_store(s, i);
                    retire_cnt = CNT_W'(k);
                    flush = f[0];
                    @(negedge clk);
                    retire_cnt = '0;
                    flush = 1'b0;
                    retire(4);
                    idle(24);
                    // R7: with a flush only the k retired stores remain
                    chk_seq(s, (f == 1) ? k : 4, g == 1);
                end
            end
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule